// File: doc/BRIEF.md
# Switch-Driven Register File Calculator

This block is a board-level top built around a small register file: eight four-bit registers with one write port and two read ports. Ten slide switches carry three fields. The low four bits are the write data. The middle three bits are an address shared by the write port and read port 1. The top three bits are the address for read port 2. A write button commits the data to the addressed register on the next rising clock edge.

Four more buttons pick what the one lit seven-segment digit shows, in a fixed order of priority: port 2, the sum, the difference, the bitwise AND, and port 1 when none of them is pressed. The result is shown as a hex digit. Inputs are assumed to be clean already, and the display is static, so no scanning or debouncing is done here.

Top module: `regcalc_top`

## Requirements
- R1: While `rstN` is low, all eight registers are cleared at once, without waiting for a clock edge, and they stay zero. `rstN` is active-low.
- R2: On a rising clock edge with `btnWrite` high, the register addressed by `slideSw[6:4]` takes the value `slideSw[3:0]`, and no other register changes.
- R3: On a clock edge with `btnWrite` low, no register changes.
- R4: Read port 1 is addressed by `slideSw[6:4]` and read port 2 by `slideSw[9:7]`. The two ports read independently and combinationally. A read of the register being written returns the old value until the edge.
- R5: The shown value is chosen in this order: `btnPort2` shows port 2; otherwise `btnSum` shows port1+port2; otherwise `btnDiff` shows port1−port2; otherwise `btnAnd` shows port1 AND port2; otherwise port 1 is shown.
- R6: The sum and the difference are truncated to four bits, which makes them modulo 16.
- R7: `segOut` is active-low. Bits 0..6 drive segments a..g, and bit 7 is the decimal point. Patterns for the digits 0..F are: C0 F9 A4 B0 99 92 82 F8 80 90 88 83 C6 A1 86 8E (hex).
- R8: `digitEn` is active-low with only bit 0 (the rightmost digit) low, so it reads 8'hFE. The decimal point, `segOut[7]`, is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous clear of all registers |
| slideSw | input | 10 | [3:0] write data, [6:4] write/port-1 address, [9:7] port-2 address |
| btnWrite | input | 1 | Write enable |
| btnPort2 | input | 1 | Show port 2 (highest priority) |
| btnSum | input | 1 | Show port1+port2 |
| btnDiff | input | 1 | Show port1−port2 |
| btnAnd | input | 1 | Show port1 AND port2 |
| segOut | output | 8 | Active-low segments a..g and decimal point |
| digitEn | output | 8 | Active-low digit enables |

## Verification
The bench builds the block with its default parameters: four-bit data, three-bit addresses and eight digits. At these values every register and all sixteen display patterns can be reached within a few hundred cycles, and so can the sum and difference wraparound at 16. Directed cases cover the following:
- a mid-cycle asynchronous clear;
- a read of the register being written;
- all buttons pressed together.

Seeded random traffic then mixes writes with every display mode and with every address pair.

// File: rtl/regcalc_pkg.sv
package regcalc_pkg;
  typedef enum logic [2:0] {
    SEL_PORT1,
    SEL_PORT2,
    SEL_SUM,
    SEL_DIFF,
    SEL_AND
  } dispSel_e;

  typedef struct packed {
    logic     wrEn;
    dispSel_e dispSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/regcalc_ctrl.sv
module regcalc_ctrl
  import regcalc_pkg::*;
(
  input  logic         btnWrite,
  input  logic         btnPort2,
  input  logic         btnSum,
  input  logic         btnDiff,
  input  logic         btnAnd,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.wrEn = btnWrite;
    if (btnPort2)     strobes.dispSel = SEL_PORT2;
    else if (btnSum)  strobes.dispSel = SEL_SUM;
    else if (btnDiff) strobes.dispSel = SEL_DIFF;
    else if (btnAnd)  strobes.dispSel = SEL_AND;
    else              strobes.dispSel = SEL_PORT1;
  end
endmodule

// File: rtl/regcalc_datapath.sv
module regcalc_datapath
  import regcalc_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] result
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regBank [DEPTH];
  logic [DEPTH-1:0]  rowWe;
  logic [DATA_W-1:0] rdA, rdB;

  for (genvar row = 0; row < DEPTH; row++) begin : g_row
    assign rowWe[row] = strobes.wrEn && (wrAddr == ADDR_W'(row));

    always_ff @(posedge clk or posedge rst) begin
      if (rst)             regBank[row] <= '0;
      else if (rowWe[row]) regBank[row] <= wrData;
    end
  end

  assign rdA = regBank[rdAddrA];
  assign rdB = regBank[rdAddrB];

  always_comb begin
    unique case (strobes.dispSel)
      SEL_PORT2: result = rdB;
      SEL_SUM:   result = rdA + rdB;
      SEL_DIFF:  result = rdA - rdB;
      SEL_AND:   result = rdA & rdB;
      default:   result = rdA;
    endcase
  end
endmodule

// File: rtl/regcalc_hex7.sv
module regcalc_hex7 (
  input  logic [3:0] nibble,
  output logic [6:0] segN
);
  always_comb begin
    unique case (nibble)
      4'h0: segN = 7'h40;
      4'h1: segN = 7'h79;
      4'h2: segN = 7'h24;
      4'h3: segN = 7'h30;
      4'h4: segN = 7'h19;
      4'h5: segN = 7'h12;
      4'h6: segN = 7'h02;
      4'h7: segN = 7'h78;
      4'h8: segN = 7'h00;
      4'h9: segN = 7'h10;
      4'hA: segN = 7'h08;
      4'hB: segN = 7'h03;
      4'hC: segN = 7'h46;
      4'hD: segN = 7'h21;
      4'hE: segN = 7'h06;
      default: segN = 7'h0E;
    endcase
  end
endmodule

// File: rtl/regcalc_top.sv
module regcalc_top
  import regcalc_pkg::*;
#(
  parameter int DATA_W     = 4,
  parameter int ADDR_W     = 3,
  parameter int NUM_DIGITS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DATA_W+2*ADDR_W-1:0]   slideSw,
  input  logic                         btnWrite,
  input  logic                         btnPort2,
  input  logic                         btnSum,
  input  logic                         btnDiff,
  input  logic                         btnAnd,
  output logic [7:0]                   segOut,
  output logic [NUM_DIGITS-1:0]        digitEn
);
  localparam int ADDR_A_LO = DATA_W;
  localparam int ADDR_B_LO = DATA_W + ADDR_W;

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] result;
  logic [6:0]        segN;
  logic              rst;

  assign rst = ~rstN;

  regcalc_ctrl i_ctrl (
    .btnWrite (btnWrite),
    .btnPort2 (btnPort2),
    .btnSum   (btnSum),
    .btnDiff  (btnDiff),
    .btnAnd   (btnAnd),
    .strobes  (strobes)
  );

  regcalc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrData  (slideSw[DATA_W-1:0]),
    .wrAddr  (slideSw[ADDR_A_LO +: ADDR_W]),
    .rdAddrA (slideSw[ADDR_A_LO +: ADDR_W]),
    .rdAddrB (slideSw[ADDR_B_LO +: ADDR_W]),
    .result  (result)
  );

  regcalc_hex7 i_hex7 (
    .nibble (result[3:0]),
    .segN   (segN)
  );

  assign segOut = {1'b1, segN};

  for (genvar dig = 0; dig < NUM_DIGITS; dig++) begin : g_digit
    assign digitEn[dig] = (dig != 0);
  end
endmodule

// File: rtl/regcalc_checks.sv
module regcalc_checks (
  input logic       clk,
  input logic       rstN,
  input logic [9:0] slideSw,
  input logic       btnWrite,
  input logic       btnPort2,
  input logic       btnSum,
  input logic       btnDiff,
  input logic       btnAnd,
  input logic [7:0] segOut,
  input logic [7:0] digitEn
);
  logic noBtn;
  assign noBtn = !btnPort2 && !btnSum && !btnDiff && !btnAnd;

  function automatic logic [6:0] hexOf(input logic [3:0] v);
    logic [6:0] t [16];
    t = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
          7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[v];
  endfunction

  assert_single_digit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (digitEn == 8'hFE) && segOut[7]);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (btnWrite && noBtn) |=>
      ((noBtn && $stable(slideSw[6:4])) -> (segOut[6:0] == hexOf($past(slideSw[3:0])))));

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!btnWrite && noBtn) |=> ((noBtn && $stable(slideSw[6:4])) -> $stable(segOut)));

  assert_port2_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (btnPort2 && $past(btnPort2) && !$past(btnWrite) && $stable(slideSw[9:7]))
      |-> $stable(segOut));
endmodule

bind regcalc_top regcalc_checks i_checks (
  .clk      (clk),
  .rstN     (rstN),
  .slideSw  (slideSw),
  .btnWrite (btnWrite),
  .btnPort2 (btnPort2),
  .btnSum   (btnSum),
  .btnDiff  (btnDiff),
  .btnAnd   (btnAnd),
  .segOut   (segOut),
  .digitEn  (digitEn)
);

// File: tb/test_regcalc_top.sv
`timescale 1ns/1ps
module test_regcalc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] slideSw = '0;
  logic       btnWrite = 1'b0, btnPort2 = 1'b0, btnSum = 1'b0, btnDiff = 1'b0, btnAnd = 1'b0;
  logic [7:0] segOut;
  logic [7:0] digitEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [3:0] model [8];

  always #5 clk = ~clk;

  regcalc_top i_regcalc_top (
    .clk(clk), .rstN(rstN), .slideSw(slideSw), .btnWrite(btnWrite),
    .btnPort2(btnPort2), .btnSum(btnSum), .btnDiff(btnDiff), .btnAnd(btnAnd),
    .segOut(segOut), .digitEn(digitEn)
  );

  function automatic logic [7:0] segFor(input logic [3:0] v);
    case (v)
      4'h0: return 8'hC0; 4'h1: return 8'hF9; 4'h2: return 8'hA4; 4'h3: return 8'hB0;
      4'h4: return 8'h99; 4'h5: return 8'h92; 4'h6: return 8'h82; 4'h7: return 8'hF8;
      4'h8: return 8'h80; 4'h9: return 8'h90; 4'hA: return 8'h88; 4'hB: return 8'h83;
      4'hC: return 8'hC6; 4'hD: return 8'hA1; 4'hE: return 8'h86; default: return 8'h8E;
    endcase
  endfunction

  function automatic logic [3:0] expValue(input logic [4:0] btns, input logic [3:0] a,
                                          input logic [3:0] b);
    // btns = {port2, sum, diff, and, unused}
    if (btns[4]) return b;
    if (btns[3]) return 4'((a + b) & 4'hF);
    if (btns[2]) return 4'((a - b) & 4'hF);
    if (btns[1]) return a & b;
    return a;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] adrB, input logic [2:0] adrA, input logic [3:0] data,
                       input logic wr, input logic [4:0] btns);
    slideSw  = {adrB, adrA, data};
    btnWrite = wr;
    btnPort2 = btns[4]; btnSum = btns[3]; btnDiff = btns[2]; btnAnd = btns[1];
  endtask

  // One cycle: drive at negedge, check the combinational view before the edge, then update the model.
  task automatic cycle(input string tag, input logic [2:0] adrB, input logic [2:0] adrA,
                       input logic [3:0] data, input logic wr, input logic [4:0] btns);
    @(negedge clk);
    drive(adrB, adrA, data, wr, btns);
    #1;
    check(tag, segOut, segFor(expValue(btns, model[adrA], model[adrB])));
    @(posedge clk);
    if (wr) model[adrA] = data;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 4'h0;
    void'($urandom(32'h5EED));
    // R1 reset state, R8 digit select
    #12;
    check("R1 reset clears display", segOut, 8'hC0);
    check("R8 digit enable", digitEn, 8'hFE);
    @(negedge clk); rstN = 1'b1;

    // R2 write eight distinct values
    for (int i = 0; i < 8; i++) cycle("R2 write", 3'd0, 3'(i), 4'((i * 5 + 3) & 15), 1'b1, 5'b0);
    for (int i = 0; i < 8; i++) cycle("R2 readback port1", 3'd0, 3'(i), 4'h0, 1'b0, 5'b0);
    // R4 independent port2 read while port1 points elsewhere
    for (int i = 0; i < 8; i++) cycle("R4 port2 read", 3'(i), 3'(7 - i), 4'h0, 1'b0, 5'b10000);

    // R3 write button low: changing data does nothing
    cycle("R3 no write", 3'd0, 3'd5, 4'hF, 1'b0, 5'b0);
    cycle("R3 hold after no write", 3'd0, 3'd5, 4'h0, 1'b0, 5'b0);

    // R4 read during write returns old then new
    cycle("R4 read-during-write old", 3'd0, 3'd2, 4'h9, 1'b1, 5'b0);
    cycle("R4 read-during-write new", 3'd0, 3'd2, 4'h9, 1'b0, 5'b0);

    // R6 wraparound: reg1=F, reg3=3
    cycle("R6 setup", 3'd0, 3'd1, 4'hF, 1'b1, 5'b0);
    cycle("R6 setup", 3'd0, 3'd3, 4'h3, 1'b1, 5'b0);
    cycle("R6 sum wraps", 3'd3, 3'd1, 4'h0, 1'b0, 5'b01000);
    cycle("R6 diff wraps", 3'd1, 3'd3, 4'h0, 1'b0, 5'b00100);
    check("R6 diff 3-F is 4", segOut, 8'h99);
    // R5 all buttons: port2 wins; sum beats diff and and
    cycle("R5 all buttons", 3'd3, 3'd1, 4'h0, 1'b0, 5'b11110);
    cycle("R5 sum over diff/and", 3'd3, 3'd1, 4'h0, 1'b0, 5'b01110);
    cycle("R5 diff over and", 3'd3, 3'd1, 4'h0, 1'b0, 5'b00110);
    cycle("R5 and alone", 3'd3, 3'd1, 4'h0, 1'b0, 5'b00010);

    // R1 asynchronous clear mid-cycle
    @(negedge clk);
    drive(3'd0, 3'd1, 4'h0, 1'b0, 5'b0);
    #1 rstN = 1'b0;
    #1 check("R1 async clear", segOut, 8'hC0);
    for (int i = 0; i < 8; i++) model[i] = 4'h0;
    @(negedge clk); rstN = 1'b1;
    cycle("R1 stays clear", 3'd1, 3'd1, 4'h0, 1'b0, 5'b01000);

    // Random traffic, R5 R6 R7 by mode
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      logic [4:0] btns;
      string tag;
      r = $urandom;
      btns = {r[12:9], 1'b0} & {5{r[13] | r[14]}};
      if (btns[4] || (!btns[3] && !btns[2])) tag = "R5 R7 random select";
      else tag = "R6 R7 random arithmetic";
      cycle(tag, r[9:7], r[6:4], r[3:0], r[15], btns);
      if (n % 50 == 0) check("R8 digit enable random", digitEn, 8'hFE);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule